// File: doc/BRIEF.md
# Hart Interrupt Controller

This block collects four level-sensitive interrupt lines and presents them to a single machine-mode hart as one external-interrupt output. Each line is a numbered source (ids 1 to 4; id 0 is reserved and means "nothing to service"). Software gives every source a 3-bit priority, chooses which sources may interrupt through an enable bitfield, and sets a priority threshold. The output is raised while any pending, enabled source has a priority strictly above the threshold.

Servicing is a loop. The handler reads the claim register, which hands back the id of the best pending, enabled source and retires its pending bit. The handler then writes that same id back to the same register to close the service. It keeps reading until the claim returns 0. A claimed source stays blocked until its completion write arrives, even while its line stays high. After completion, a line that is still high becomes pending again on the next cycle.

The register port is a 32-bit request/response port. A requester raises `bus_valid_i` with write flag, address and write data, and holds all of them steady until it sees `bus_ready_o`. The block samples the request on the first clock edge where valid is high and ready is low. It raises `bus_ready_o` for exactly one cycle after that edge, with read data valid in the same cycle. The transfer is finished when valid and ready are both high. Each access therefore takes two cycles, and the block never accepts a new request in the cycle in which ready is high.

Top module: `hart_intc`

## Requirements
- R1: After reset all priorities, the enable field, the threshold and all pending and in-service state are zero, `ext_irq_o` and `bus_ready_o` are low, and a claim read returns 0.
- R2: A request sampled while `bus_ready_o` is low raises `bus_ready_o` in the next cycle for one cycle only. Read data is valid in that cycle. `bus_ready_o` is never high unless `bus_valid_i` was high in the cycle before.
- R3: The priority of source i (1..4) is at byte address 4*i and holds 3 bits (write data bits 2:0). Reads return that value zero-extended, and write data bits above bit 2 are dropped.
- R4: Address 0x1000 reads the pending field, with bit i for source i and bit 0 always 0. A high input sets its pending bit on the next clock edge. Pending stays set until the source is claimed. Writes to this address change nothing.
- R5: Address 0x2000 holds the enable field, with bit i enabling source i. Only bits 4..1 are stored, so writing 0xFFFFFFFF reads back 0x1E.
- R6: Address 0x200000 holds a 3-bit threshold. `ext_irq_o` is high exactly when some pending, enabled source has a priority strictly greater than the threshold.
- R7: A read of 0x200004 returns the id of the pending, enabled source with the highest non-zero priority, independent of the threshold. Among equal priorities the lower id wins. The read returns 0 when no source qualifies, and a priority-0 source is never returned.
- R8: A claim read clears the returned source's pending bit and marks it in service. While in service, the source does not become pending again, whatever its input does.
- R9: A write of id k to 0x200004 ends service of source k if it is in service. If its input is still high, the source is pending again one cycle later. A write of 0, of an id above 4, or of an id not in service has no effect.
- R10: Every other address, including misaligned ones and address 0, reads as 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 4 | Level interrupt inputs; bit k is source k+1 |
| bus_valid_i | input | 1 | Register request valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 22 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while `bus_ready_o` is high |
| bus_ready_o | output | 1 | Response strobe, one cycle per request |
| ext_irq_o | output | 1 | External interrupt request to the hart |

## Verification
The hardest state to reach from the ports is a source whose line stays high while it is in service, combined with completion writes that name the wrong id. Reaching it needs a claim, a held input, several stray completions and then the right one, all in order. Directed steps build exactly that chain: all four lines high with a tied priority pair and a priority-0 source, claims drained to 0, then wrong and right completions. After that, a fixed-seed random mix of line changes, register writes, claims and completions with random ids (including unclaimed ones) runs against a bench reference model.

// File: rtl/hintc_pkg.sv
package hintc_pkg;
  // byte offsets of the shared registers; per-source priorities sit at 4*id
  localparam int unsigned PEND_OFS  = 32'h0000_1000;
  localparam int unsigned EN_OFS    = 32'h0000_2000;
  localparam int unsigned THR_OFS   = 32'h0020_0000;
  localparam int unsigned CLAIM_OFS = 32'h0020_0004;
endpackage

// File: rtl/hintc_gateway.sv
module hintc_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic busy_o
);
  logic pend_q, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (claim_i) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
    end else if (complete_i) begin
      busy_q <= 1'b0;
    end else if (level_i && !busy_q) begin
      pend_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
  assign busy_o    = busy_q;

  // R8: only a pending source may be claimed
  assert_claim_of_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> pend_q);
  // R8: in-service source is never pending at the same time
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pend_q);
  // R9: service persists until a completion arrives
  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !complete_i) |=> busy_q);
endmodule

// File: rtl/hintc_select.sv
module hintc_select #(
  parameter int NSRC   = 4,
  parameter int PRIO_W = 3,
  parameter int IDW    = 3
) (
  input  logic [NSRC-1:0]             pend_i,
  input  logic [NSRC-1:0]             en_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic [IDW-1:0]              id_o,
  output logic [PRIO_W-1:0]           prio_o
);
  always_comb begin
    logic [IDW-1:0]    bid;
    logic [PRIO_W-1:0] bpr;
    bid = '0;
    bpr = '0;
    // ascending scan, strict compare: lower id keeps a tie, priority 0 never wins
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > bpr)) begin
        bpr = prio_i[i];
        bid = IDW'(i + 1);
      end
    end
    id_o   = bid;
    prio_o = bpr;
  end
endmodule

// File: rtl/hart_intc.sv
module hart_intc #(
  parameter int NSRC   = 4,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_lines_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_ready_o,
  output logic              ext_irq_o
);
  import hintc_pkg::*;

  localparam int IDW = $clog2(NSRC + 1);
  localparam logic [ADDR_W-1:0] PEND_A  = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] EN_A    = ADDR_W'(EN_OFS);
  localparam logic [ADDR_W-1:0] THR_A   = ADDR_W'(THR_OFS);
  localparam logic [ADDR_W-1:0] CLAIM_A = ADDR_W'(CLAIM_OFS);

  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NSRC-1:0]             en_q;
  logic [PRIO_W-1:0]           thr_q;
  logic [NSRC-1:0]             pend, busy, claim_v, done_v;
  logic [IDW-1:0]              best_id;
  logic [PRIO_W-1:0]           best_prio;
  logic                        resp_q;
  logic [31:0]                 rdata_q, rd_mux;

  wire access   = bus_valid_i && !resp_q;
  wire wr       = access && bus_write_i;
  wire rd_claim = access && !bus_write_i && (bus_addr_i == CLAIM_A);
  wire wr_claim = wr && (bus_addr_i == CLAIM_A);

  // per-source gateways
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign claim_v[g] = rd_claim && (best_id == IDW'(g + 1));
    assign done_v[g]  = wr_claim && (bus_wdata_i == 32'(g + 1));
    hintc_gateway u_gw (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (irq_lines_i[g]),
      .claim_i    (claim_v[g]),
      .complete_i (done_v[g]),
      .pending_o  (pend[g]),
      .busy_o     (busy[g])
    );
  end

  hintc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_sel (
    .pend_i (pend),
    .en_i   (en_q),
    .prio_i (prio_q),
    .id_o   (best_id),
    .prio_o (best_prio)
  );

  assign ext_irq_o = (best_prio > thr_q);

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr) begin
      for (int i = 0; i < NSRC; i++)
        if (bus_addr_i == ADDR_W'(4 * (i + 1))) prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
      if (bus_addr_i == EN_A)  en_q  <= bus_wdata_i[NSRC:1];
      if (bus_addr_i == THR_A) thr_q <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  // read decode
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSRC; i++)
      if (bus_addr_i == ADDR_W'(4 * (i + 1))) rd_mux = 32'(prio_q[i]);
    if (bus_addr_i == PEND_A)  rd_mux = 32'({pend, 1'b0});
    if (bus_addr_i == EN_A)    rd_mux = 32'({en_q, 1'b0});
    if (bus_addr_i == THR_A)   rd_mux = 32'(thr_q);
    if (bus_addr_i == CLAIM_A) rd_mux = 32'(best_id);
  end

  // response stage: one-cycle ready strobe after each sampled request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q <= access;
      if (access) rdata_q <= bus_write_i ? 32'h0 : rd_mux;
    end
  end

  assign bus_ready_o = resp_q;
  assign bus_rdata_o = rdata_q;

  // R2: ready is a single-cycle strobe
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready_o |=> !bus_ready_o);
  // R2: ready answers a request seen one cycle earlier
  assert_ready_after_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready_o |-> $past(bus_valid_i));
  // R6: an asserted interrupt always has a claimable source behind it
  assert_irq_claimable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_o |-> (best_id != '0));
  // R8: at most one source is claimed per access
  assert_single_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_v));
endmodule

// File: tb/hart_intc_tb.sv
module hart_intc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_lines = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, ext_irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hart_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(irq_lines),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_ready_o(bus_ready),
    .ext_irq_o(ext_irq)
  );

  // reference model
  int unsigned m_prio [1:4];
  logic [4:1]  m_en, m_pend, m_busy, m_src;
  int unsigned m_thr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void settle();
    for (int i = 1; i <= 4; i++)
      if (m_src[i] && !m_busy[i]) m_pend[i] = 1'b1;
  endfunction

  function automatic int unsigned best_id();
    int unsigned bp = 0, bi = 0;
    for (int i = 1; i <= 4; i++)
      if (m_pend[i] && m_en[i] && m_prio[i] > bp) begin bp = m_prio[i]; bi = i; end
    return bi;
  endfunction

  function automatic logic exp_irq();
    int unsigned b = best_id();
    return (b != 0) && (m_prio[b] > m_thr);
  endfunction

  function automatic logic [31:0] exp_read(input logic [21:0] a);
    case (a)
      22'h4, 22'h8, 22'hC, 22'h10: return m_prio[a / 4];
      22'h1000:   return 32'({m_pend, 1'b0});
      22'h2000:   return 32'({m_en, 1'b0});
      22'h200000: return m_thr;
      default:    return 32'h0;
    endcase
  endfunction

  task automatic xfer(input logic wr, input logic [21:0] a, input logic [31:0] d,
                      output logic [31:0] r);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    chk("R2 ready strobe high", 32'(bus_ready), 32'd1);
    r = bus_rdata;
    @(posedge clk); @(negedge clk);
    chk("R2 ready strobe one cycle", 32'(bus_ready), 32'd0);
    bus_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [21:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, d, r);
    case (a)
      22'h4, 22'h8, 22'hC, 22'h10: m_prio[a / 4] = d & 32'h7;
      22'h2000:   m_en = d[4:1];
      22'h200000: m_thr = d & 32'h7;
      22'h200004: if (d >= 1 && d <= 4 && m_busy[d]) m_busy[d] = 1'b0;
      default: ;
    endcase
    settle();
  endtask

  task automatic do_rd(input string tag, input logic [21:0] a);
    logic [31:0] r;
    xfer(1'b0, a, 32'h0, r);
    chk(tag, r, exp_read(a));
  endtask

  task automatic do_claim(input string tag);
    logic [31:0] r;
    int unsigned e = best_id();
    xfer(1'b0, 22'h200004, 32'h0, r);
    chk(tag, r, e);
    if (e != 0) begin m_pend[e] = 1'b0; m_busy[e] = 1'b1; end
    settle();
  endtask

  task automatic set_src(input logic [3:0] v);
    irq_lines = v; m_src = v;
    @(posedge clk); @(negedge clk);
    settle();
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, 32'(ext_irq), 32'(exp_irq()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [21:0] odd_addr [7];
    odd_addr = '{22'h0, 22'h14, 22'h1004, 22'h2004, 22'h3000, 22'h200008, 22'h5};
    for (int i = 1; i <= 4; i++) m_prio[i] = 0;
    m_en = '0; m_pend = '0; m_busy = '0; m_src = '0; m_thr = 0;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready low", 32'(bus_ready), 32'd0);
    chk("R1 irq low", 32'(ext_irq), 32'd0);
    do_rd("R1 pending zero", 22'h1000);
    do_rd("R1 enable zero", 22'h2000);
    do_rd("R1 threshold zero", 22'h200000);
    do_claim("R1 claim returns 0");

    // R3 / R5: field widths
    do_wr(22'h4, 32'hFF);
    do_rd("R3 priority 3-bit", 22'h4);
    chk("R3 priority value", exp_read(22'h4), 32'd7);
    do_wr(22'h2000, 32'hFFFF_FFFF);
    do_rd("R5 enable field 0x1E", 22'h2000);
    chk("R5 model enable", exp_read(22'h2000), 32'h1E);

    // tie and priority 0 set-up
    do_wr(22'h4, 32'd2);
    do_wr(22'h8, 32'd5);
    do_wr(22'hC, 32'd5);
    do_wr(22'h10, 32'd0);
    set_src(4'hF);
    do_rd("R4 all pending", 22'h1000);
    chk("R4 pending value", exp_read(22'h1000), 32'h1E);
    chk_irq("R6 irq threshold 0");
    do_wr(22'h200000, 32'd5);
    chk("R6 equal to threshold no irq", 32'(ext_irq), 32'd0);
    do_wr(22'h200000, 32'd4);
    chk("R6 above threshold irq", 32'(ext_irq), 32'd1);

    // R7 claim order; R8 blocking while high
    do_claim("R7 tie lower id");
    do_claim("R7 second of tie");
    do_claim("R7 lower priority");
    do_claim("R7 priority 0 never claimed");
    repeat (4) @(negedge clk);
    do_rd("R8 claimed stay clear with input high", 22'h1000);
    chk("R8 pending only source 4", exp_read(22'h1000), 32'h10);
    chk_irq("R6 irq after drain");

    // R9 completion
    do_wr(22'h200004, 32'd4);
    do_rd("R9 unclaimed completion ignored", 22'h1000);
    do_wr(22'h200004, 32'd0);
    do_wr(22'h200004, 32'd7);
    do_rd("R9 zero/out-of-range completion ignored", 22'h1000);
    do_wr(22'h200004, 32'd2);
    do_rd("R9 re-pend after completion", 22'h1000);
    chk("R9 pending value", exp_read(22'h1000), 32'h14);
    do_claim("R9 reclaim after completion");

    // R10 unmapped and R4 read-only pending
    for (int k = 0; k < 7; k++) begin
      do_wr(odd_addr[k], 32'hFFFF_FFFF);
      do_rd("R10 unmapped reads 0", odd_addr[k]);
    end
    do_wr(22'h1000, 32'h0);
    do_rd("R4 pending write ignored", 22'h1000);
    do_rd("R10 priorities intact", 22'h8);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0: set_src(4'($urandom_range(0, 15)));
        1: do_wr(22'(4 * $urandom_range(1, 4)), $urandom);
        2: do_wr(22'h2000, $urandom);
        3: do_wr(22'h200000, $urandom_range(0, 1) ? $urandom : $urandom_range(0, 7));
        4, 5: do_claim("R7 random claim");
        6: do_wr(22'h200004, $urandom_range(0, 5));
        default: begin
          int s = $urandom_range(0, 11);
          if (s < 7) begin
            if ($urandom_range(0, 1) != 0) do_wr(odd_addr[s], $urandom);
            do_rd("R10 random unmapped", odd_addr[s]);
          end else if (s == 7) do_rd("R4 random pending", 22'h1000);
          else if (s == 8) do_rd("R5 random enable", 22'h2000);
          else if (s == 9) do_rd("R6 random threshold", 22'h200000);
          else do_rd("R3 random priority", 22'(4 * $urandom_range(1, 4)));
        end
      endcase
      chk_irq("R6 random irq");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule